// File: doc/BRIEF.md
# Flash Program and Erase Chunk Sequencer

This block turns one large flash request (a read, a page program or an erase, given as a start address and a byte count) into a series of sub-operations that a flash command engine can carry out one at a time. Reads are cut into pieces no larger than the staging buffer. Programs are cut so that no piece crosses a page. Erases use the largest configured erase granule that both the current address and the bytes still left are aligned to.

For each piece the sequencer drives an address, an opcode and a length, then pulses a start strobe. It then checks the engine's completion flag once per poll interval. The next piece starts only after completion is seen. The sequence ends with a one-cycle done pulse and a status code. A request is taken only while the block is idle. Moving data through the staging buffer is handled elsewhere.

Top module: `flash_chunk_seq`

## Requirements
- R1: After reset, req_ready is 1, chunk_start and seq_done are 0, and seq_status is 0 (OK).
- R2: A read request (req_kind 0, or the unused code 3) issues chunks with opcode 0. Each chunk is BUF_BYTES long (256 by default), except the last, which takes what remains.
- R3: A program request (req_kind 1) issues opcode-1 chunks. Each is PAGE_BYTES minus (address mod PAGE_BYTES), capped at the remaining count, so no chunk crosses a page.
- R4: In an erase request (req_kind 2), a step whose address and remaining size are both multiples of the usable large erase size issues opcode 3 with that length.
- R5: Failing R4, a step aligned the same way to the usable small erase size issues opcode 2 with that length. A step that fits neither ends the sequence with status 1 (alignment error) and issues no more chunks.
- R6: An erase size input other than 4096, 32768 or 65536 is treated as unusable (zero).
- R7: An erase request ends with status 2 (configuration mismatch) and no chunk when both sizes are unusable, or when the small size exceeds a non-zero large size.
- R8: The engine's completion flag is sampled only once every POLL_IVL cycles after a chunk starts. If no completion is seen within MAX_POLLS samples, the sequence ends with status 3 (timeout) exactly POLL_IVL*MAX_POLLS cycles after the start strobe.
- R9: After each completed chunk, the address advances and the remaining count drops by the chunk length. Status 0 is reported when nothing remains.
- R10: A zero-byte read or program request finishes with status 0 and no chunk, with seq_done one cycle after the request is taken.
- R11: An engine error flag seen together with completion ends the sequence with status 4 and issues no further chunk.
- R12: chunk_start lasts one cycle. chunk_addr, chunk_op and chunk_len change only together with chunk_start.
- R13: req_valid is ignored while a sequence is running. Other inputs are taken only when a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is 1 |
| req_kind | input | 2 | 0 read, 1 program, 2 erase, 3 read |
| req_addr | input | AW | Start byte address |
| req_size | input | AW | Byte count |
| small_erase_size | input | AW | Configured small erase granule in bytes |
| large_erase_size | input | AW | Configured large erase granule in bytes |
| req_ready | output | 1 | Idle, able to take a request |
| chunk_start | output | 1 | One-cycle start strobe to the engine |
| chunk_addr | output | AW | Chunk start address |
| chunk_op | output | 2 | 0 read, 1 program, 2 small erase, 3 large erase |
| chunk_len | output | LENW | Chunk length in bytes |
| eng_done | input | 1 | Engine completion flag (level) |
| eng_err | input | 1 | Engine error flag, valid with eng_done |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |
| seq_status | output | 3 | 0 OK, 1 alignment, 2 configuration, 3 timeout, 4 engine error |

## Verification
The bench builds the block with POLL_IVL 4 and MAX_POLLS 6 in place of the defaults, which are sized for a one-second limit. This puts the timeout within a few dozen cycles. It also makes the spacing between successive chunk strobes an exact multiple of the poll interval plus one, for both short and long engine latencies. The buffer, page and address widths stay at their defaults, so page splits and all three erase granules are exercised at their real sizes.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

   typedef enum logic [1:0] {
      KIND_READ  = 2'd0,
      KIND_PROG  = 2'd1,
      KIND_ERASE = 2'd2
   } kind_e;

   typedef enum logic [1:0] {
      OP_READ     = 2'd0,
      OP_PROG     = 2'd1,
      OP_ERASE_SM = 2'd2,
      OP_ERASE_LG = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      ST_OK      = 3'd0,
      ST_ALIGN   = 3'd1,
      ST_CFG     = 3'd2,
      ST_TIMEOUT = 3'd3,
      ST_ENGINE  = 3'd4
   } status_e;

   localparam int unsigned GRAN_4K  = 4096;
   localparam int unsigned GRAN_32K = 32768;
   localparam int unsigned GRAN_64K = 65536;

endpackage

// File: rtl/fseq_erase_cfg.sv
module fseq_erase_cfg #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] small_raw,
   input  logic [AW-1:0] large_raw,
   output logic [AW-1:0] small_sz,
   output logic [AW-1:0] large_sz,
   output logic          cfg_bad
);
   import fseq_pkg::*;

   logic [AW-1:0] raw_v  [2];
   logic [AW-1:0] good_v [2];

   assign raw_v[0] = small_raw;
   assign raw_v[1] = large_raw;

   for (genvar g = 0; g < 2; g++) begin : g_gran
      always_comb begin
         if (raw_v[g] == AW'(GRAN_4K) || raw_v[g] == AW'(GRAN_32K) ||
             raw_v[g] == AW'(GRAN_64K))
            good_v[g] = raw_v[g];
         else
            good_v[g] = '0;
      end
   end

   assign small_sz = good_v[0];
   assign large_sz = good_v[1];
   assign cfg_bad  = (good_v[0] == '0 && good_v[1] == '0) ||
                     (good_v[1] != '0 && good_v[0] > good_v[1]);

endmodule

// File: rtl/fseq_chunk_plan.sv
module fseq_chunk_plan #(
   parameter int AW         = 32,
   parameter int LENW       = 17,
   parameter int BUF_BYTES  = 256,
   parameter int PAGE_BYTES = 256
) (
   input  fseq_pkg::kind_e kind,
   input  logic [AW-1:0]   addr,
   input  logic [AW-1:0]   rem,
   input  logic [AW-1:0]   small_sz,
   input  logic [AW-1:0]   large_sz,
   output logic [LENW-1:0] len,
   output fseq_pkg::op_e   op,
   output logic            align_err
);
   import fseq_pkg::*;

   localparam logic [AW-1:0] PAGE_W = AW'(PAGE_BYTES);
   localparam logic [AW-1:0] PMASK  = AW'(PAGE_BYTES - 1);
   localparam logic [AW-1:0] BUF_W  = AW'(BUF_BYTES);

   logic [AW-1:0] room, pick, combo;

   always_comb begin
      room      = PAGE_W - (addr & PMASK);
      combo     = addr | rem;
      pick      = '0;
      op        = OP_READ;
      align_err = 1'b0;
      case (kind)
         KIND_PROG: begin
            op   = OP_PROG;
            pick = (rem < room) ? rem : room;
         end
         KIND_ERASE: begin
            if (large_sz != '0 && (combo & (large_sz - AW'(1))) == '0) begin
               op   = OP_ERASE_LG;
               pick = large_sz;
            end else if (small_sz != '0 && (combo & (small_sz - AW'(1))) == '0) begin
               op   = OP_ERASE_SM;
               pick = small_sz;
            end else begin
               align_err = 1'b1;
            end
         end
         default: begin
            op   = OP_READ;
            pick = (rem < BUF_W) ? rem : BUF_W;
         end
      endcase
      len = LENW'(pick);
   end

endmodule

// File: rtl/fseq_poll_timer.sv
module fseq_poll_timer #(
   parameter int POLL_IVL  = 20000,
   parameter int MAX_POLLS = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic tick,
   output logic last_poll
);
   localparam int PW = $clog2(MAX_POLLS + 1);

   logic [PW-1:0] polls_q;

   if (POLL_IVL == 1) begin : g_every
      assign tick = run;
   end else begin : g_count
      localparam int IW = $clog2(POLL_IVL);
      logic [IW-1:0] ivl_q;
      assign tick = run && (ivl_q == IW'(POLL_IVL - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      ivl_q <= '0;
         else if (clear)  ivl_q <= '0;
         else if (run)    ivl_q <= tick ? '0 : ivl_q + IW'(1);
      end
   end

   assign last_poll = tick && (polls_q == PW'(MAX_POLLS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  polls_q <= '0;
      else if (clear)              polls_q <= '0;
      else if (tick && !last_poll) polls_q <= polls_q + PW'(1);
   end

endmodule

// File: rtl/flash_chunk_seq.sv
module flash_chunk_seq #(
   parameter int AW         = 32,
   parameter int LENW       = 17,
   parameter int BUF_BYTES  = 256,
   parameter int PAGE_BYTES = 256,
   parameter int POLL_IVL   = 20000,
   parameter int MAX_POLLS  = 10000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [1:0]      req_kind,
   input  logic [AW-1:0]   req_addr,
   input  logic [AW-1:0]   req_size,
   input  logic [AW-1:0]   small_erase_size,
   input  logic [AW-1:0]   large_erase_size,
   output logic            req_ready,
   output logic            chunk_start,
   output logic [AW-1:0]   chunk_addr,
   output logic [1:0]      chunk_op,
   output logic [LENW-1:0] chunk_len,
   input  logic            eng_done,
   input  logic            eng_err,
   output logic            seq_done,
   output logic [2:0]      seq_status
);
   import fseq_pkg::*;

   if (AW < 17) begin : g_bad_aw
      $error("AW must hold a 64 KiB erase granule");
   end
   if (LENW < 17 || BUF_BYTES > (1 << (LENW - 1))) begin : g_bad_lenw
      $error("LENW too narrow for chunk lengths");
   end
   if (PAGE_BYTES < 1 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if (BUF_BYTES < 1 || POLL_IVL < 1 || MAX_POLLS < 1) begin : g_bad_cnt
      $error("BUF_BYTES, POLL_IVL and MAX_POLLS must be positive");
   end

   typedef enum logic [1:0] {S_IDLE, S_STEP, S_WAIT} state_e;

   state_e          state_q;
   kind_e           kind_q;
   logic [AW-1:0]   addr_q, rem_q, sm_q, lg_q;
   logic            cfg_bad_q;
   logic [AW-1:0]   sm_v, lg_v;
   logic            cfg_bad_v;
   logic [LENW-1:0] plan_len;
   op_e             plan_op;
   logic            plan_err;
   logic            tick, last_poll;
   logic            start_q, done_q;
   logic [AW-1:0]   caddr_q;
   logic [1:0]      cop_q;
   logic [LENW-1:0] clen_q;
   status_e         status_q;

   fseq_erase_cfg #(.AW(AW)) u_cfg (
      .small_raw (small_erase_size),
      .large_raw (large_erase_size),
      .small_sz  (sm_v),
      .large_sz  (lg_v),
      .cfg_bad   (cfg_bad_v)
   );

   fseq_chunk_plan #(
      .AW(AW), .LENW(LENW), .BUF_BYTES(BUF_BYTES), .PAGE_BYTES(PAGE_BYTES)
   ) u_plan (
      .kind      (kind_q),
      .addr      (addr_q),
      .rem       (rem_q),
      .small_sz  (sm_q),
      .large_sz  (lg_q),
      .len       (plan_len),
      .op        (plan_op),
      .align_err (plan_err)
   );

   fseq_poll_timer #(.POLL_IVL(POLL_IVL), .MAX_POLLS(MAX_POLLS)) u_poll (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (state_q == S_STEP),
      .run       (state_q == S_WAIT),
      .tick      (tick),
      .last_poll (last_poll)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         kind_q    <= KIND_READ;
         addr_q    <= '0;
         rem_q     <= '0;
         sm_q      <= '0;
         lg_q      <= '0;
         cfg_bad_q <= 1'b0;
         start_q   <= 1'b0;
         done_q    <= 1'b0;
         caddr_q   <= '0;
         cop_q     <= '0;
         clen_q    <= '0;
         status_q  <= ST_OK;
      end else begin
         start_q <= 1'b0;
         done_q  <= 1'b0;
         case (state_q)
            S_IDLE: begin
               if (req_valid) begin
                  kind_q    <= kind_e'(req_kind);
                  addr_q    <= req_addr;
                  rem_q     <= req_size;
                  sm_q      <= sm_v;
                  lg_q      <= lg_v;
                  cfg_bad_q <= cfg_bad_v;
                  state_q   <= S_STEP;
               end
            end
            S_STEP: begin
               if (kind_q == KIND_ERASE && cfg_bad_q) begin
                  done_q   <= 1'b1;
                  status_q <= ST_CFG;
                  state_q  <= S_IDLE;
               end else if (rem_q == '0) begin
                  done_q   <= 1'b1;
                  status_q <= ST_OK;
                  state_q  <= S_IDLE;
               end else if (plan_err) begin
                  done_q   <= 1'b1;
                  status_q <= ST_ALIGN;
                  state_q  <= S_IDLE;
               end else begin
                  caddr_q <= addr_q;
                  cop_q   <= plan_op;
                  clen_q  <= plan_len;
                  start_q <= 1'b1;
                  state_q <= S_WAIT;
               end
            end
            S_WAIT: begin
               if (tick) begin
                  if (eng_done && eng_err) begin
                     done_q   <= 1'b1;
                     status_q <= ST_ENGINE;
                     state_q  <= S_IDLE;
                  end else if (eng_done) begin
                     addr_q  <= addr_q + AW'(clen_q);
                     rem_q   <= rem_q - AW'(clen_q);
                     state_q <= S_STEP;
                  end else if (last_poll) begin
                     done_q   <= 1'b1;
                     status_q <= ST_TIMEOUT;
                     state_q  <= S_IDLE;
                  end
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign req_ready   = (state_q == S_IDLE);
   assign chunk_start = start_q;
   assign chunk_addr  = caddr_q;
   assign chunk_op    = cop_q;
   assign chunk_len   = clen_q;
   assign seq_done    = done_q;
   assign seq_status  = status_q;

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
   parameter int AW         = 32,
   parameter int LENW       = 17,
   parameter int BUF_BYTES  = 256,
   parameter int PAGE_BYTES = 256
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_ready,
   input logic            chunk_start,
   input logic [AW-1:0]   chunk_addr,
   input logic [1:0]      chunk_op,
   input logic [LENW-1:0] chunk_len,
   input logic            seq_done
);
   localparam logic [AW-1:0] PMASK = AW'(PAGE_BYTES - 1);

   // R12
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_start |=> !chunk_start);

   // R12
   chunk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chunk_start |-> ($stable(chunk_addr) && $stable(chunk_len) && $stable(chunk_op)));

   // R2
   read_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chunk_start && chunk_op == 2'd0) |->
         (chunk_len != '0 && chunk_len <= LENW'(BUF_BYTES)));

   // R3
   page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chunk_start && chunk_op == 2'd1) |->
         (chunk_len != '0 && ((chunk_addr & PMASK) + AW'(chunk_len)) <= AW'(PAGE_BYTES)));

   // R4
   erase_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chunk_start && chunk_op[1]) |->
         ((chunk_addr & (AW'(chunk_len) - AW'(1))) == '0 &&
          (chunk_len == LENW'(4096) || chunk_len == LENW'(32768) ||
           chunk_len == LENW'(65536))));

   // R13
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_start |-> !req_ready);

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> (req_ready && !chunk_start));

endmodule

bind flash_chunk_seq fseq_chk #(
   .AW(AW), .LENW(LENW), .BUF_BYTES(BUF_BYTES), .PAGE_BYTES(PAGE_BYTES)
) u_fseq_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ready   (req_ready),
   .chunk_start (chunk_start),
   .chunk_addr  (chunk_addr),
   .chunk_op    (chunk_op),
   .chunk_len   (chunk_len),
   .seq_done    (seq_done)
);

// File: tb/tb_flash_chunk_seq.sv
`timescale 1ns/1ps
module tb_flash_chunk_seq;
   localparam int AW = 32, LENW = 17, IVL = 4, MAXP = 6, MAXC = 64;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_kind = '0;
   logic [AW-1:0] req_addr = '0, req_size = '0, sm_in = '0, lg_in = '0;
   logic req_ready, chunk_start, seq_done;
   logic [AW-1:0] chunk_addr;
   logic [1:0] chunk_op;
   logic [LENW-1:0] chunk_len;
   logic [2:0] seq_status;
   logic eng_done = 1'b0, eng_err = 1'b0;

   always #2.5 clk = ~clk;

   flash_chunk_seq #(.AW(AW), .LENW(LENW), .POLL_IVL(IVL), .MAX_POLLS(MAXP)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_size(req_size), .small_erase_size(sm_in),
      .large_erase_size(lg_in), .req_ready(req_ready), .chunk_start(chunk_start),
      .chunk_addr(chunk_addr), .chunk_op(chunk_op), .chunk_len(chunk_len),
      .eng_done(eng_done), .eng_err(eng_err), .seq_done(seq_done),
      .seq_status(seq_status)
   );

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit finished = 0;

   longint rec_addr [MAXC];
   int     rec_op   [MAXC];
   longint rec_len  [MAXC];
   int     rec_cyc  [MAXC];
   int     n_rec = 0, dbl = 0;
   bit     prev_start = 0;
   int     eng_lat = 1, eng_err_at = -1, eng_cnt = 0, eng_idx = 0;

   longint exp_addr [MAXC];
   int     exp_op   [MAXC];
   longint exp_len  [MAXC];
   int     exp_n = 0, exp_status = 0;

   int got_status = 0, done_cyc = 0, wait_n = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // engine model and chunk monitor
   always @(negedge clk) begin
      if (rst_n && chunk_start) begin
         if (n_rec < MAXC) begin
            rec_addr[n_rec] = chunk_addr;
            rec_op[n_rec]   = chunk_op;
            rec_len[n_rec]  = chunk_len;
            rec_cyc[n_rec]  = cyc;
         end
         eng_idx  = n_rec;
         n_rec    = n_rec + 1;
         eng_done = 1'b0;
         eng_err  = 1'b0;
         eng_cnt  = eng_lat;
      end else if (eng_cnt > 0) begin
         eng_cnt = eng_cnt - 1;
         if (eng_cnt == 0) begin
            eng_done = 1'b1;
            eng_err  = (eng_idx == eng_err_at);
         end
      end
      if (prev_start && chunk_start) dbl = dbl + 1;
      prev_start = chunk_start;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic longint usable(input longint s);
      return (s == 4096 || s == 32768 || s == 65536) ? s : 0;
   endfunction

   // expected chunk list built from the requirements
   task automatic model(input int kind, input longint addr, input longint size,
                        input longint sm_raw, input longint lg_raw);
      longint a = addr, r = size, sm = usable(sm_raw), lg = usable(lg_raw), l;
      int op;
      exp_n = 0; exp_status = 0;
      if (kind == 2 && ((sm == 0 && lg == 0) || (lg != 0 && sm > lg))) begin
         exp_status = 2;
         return;
      end
      while (r > 0) begin
         if (kind == 1) begin
            op = 1; l = 256 - (a % 256); if (l > r) l = r;
         end else if (kind == 2) begin
            if (lg != 0 && (a % lg) == 0 && (r % lg) == 0) begin
               op = 3; l = lg;
            end else if (sm != 0 && (a % sm) == 0 && (r % sm) == 0) begin
               op = 2; l = sm;
            end else begin
               exp_status = 1;
               return;
            end
         end else begin
            op = 0; l = (r > 256) ? 256 : r;
         end
         exp_addr[exp_n] = a; exp_op[exp_n] = op; exp_len[exp_n] = l;
         exp_n++;
         a += l; r -= l;
      end
   endtask

   task automatic run_req(input int kind, input longint addr, input longint size,
                          input longint sm, input longint lg, input bit noise);
      n_rec = 0; eng_cnt = 0; eng_done = 1'b0; eng_err = 1'b0;
      @(negedge clk);
      req_kind = kind[1:0]; req_addr = addr[AW-1:0]; req_size = size[AW-1:0];
      sm_in = sm[AW-1:0]; lg_in = lg[AW-1:0];
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_n = 0;
      while (!seq_done && wait_n < 5000) begin
         if (noise) begin
            req_valid = 1'b1; req_kind = 2'd2; req_addr = '0; req_size = 32'h1000;
         end
         @(negedge clk);
         wait_n++;
      end
      req_valid = 1'b0;
      chk(seq_done == 1'b1, "R9 sequence end seen", seq_done, 1);
      got_status = seq_status;
      done_cyc   = cyc;
   endtask

   task automatic compare(input string tag);
      chk(got_status == exp_status, {tag, " status"}, got_status, exp_status);
      chk(n_rec == exp_n, {tag, " chunk count"}, n_rec, exp_n);
      for (int i = 0; i < exp_n && i < n_rec && i < MAXC; i++) begin
         chk(rec_addr[i] == exp_addr[i], {tag, " addr"}, rec_addr[i], exp_addr[i]);
         chk(rec_op[i] == exp_op[i], {tag, " op"}, rec_op[i], exp_op[i]);
         chk(rec_len[i] == exp_len[i], {tag, " len"}, rec_len[i], exp_len[i]);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
      chk(chunk_start == 1'b0, "R1 start", chunk_start, 0);
      chk(seq_done == 1'b0, "R1 done", seq_done, 0);
      chk(seq_status == 3'd0, "R1 status", seq_status, 0);
   endtask

   task automatic t_read;
      eng_lat = 1; eng_err_at = -1;
      run_req(0, 32'h1F0, 600, 4096, 65536, 1'b0);
      model(0, 32'h1F0, 600, 4096, 65536);
      compare("R2 read");
      // R8: done visible before first poll, so strobes are IVL+1 apart
      chk(rec_cyc[1] - rec_cyc[0] == IVL + 1, "R8 short latency spacing",
          rec_cyc[1] - rec_cyc[0], IVL + 1);
      run_req(3, 32'h40, 100, 0, 0, 1'b0);
      model(0, 32'h40, 100, 0, 0);
      compare("R2 code3 read");
   endtask

   task automatic t_prog;
      eng_lat = 9; eng_err_at = -1;
      run_req(1, 32'h1F0, 600, 4096, 65536, 1'b0);
      model(1, 32'h1F0, 600, 4096, 65536);
      compare("R3 R9 program");
      // R8: done rises 10 cycles in, third poll at 12, next strobe at 13
      chk(rec_cyc[1] - rec_cyc[0] == 13, "R8 long latency spacing",
          rec_cyc[1] - rec_cyc[0], 13);
      eng_lat = 1;
   endtask

   task automatic t_erase;
      eng_lat = 1; eng_err_at = -1;
      run_req(2, 0, 32'h20000, 4096, 65536, 1'b0);
      model(2, 0, 32'h20000, 4096, 65536);
      compare("R4 large erase");
      run_req(2, 32'h7000, 32'h9000, 4096, 32768, 1'b0);
      model(2, 32'h7000, 32'h9000, 4096, 32768);
      compare("R5 small then large erase");
      run_req(2, 32'h800, 32'h1000, 4096, 65536, 1'b0);
      model(2, 32'h800, 32'h1000, 4096, 65536);
      compare("R5 misaligned start");
      run_req(2, 0, 32'h1800, 4096, 65536, 1'b0);
      model(2, 0, 32'h1800, 4096, 65536);
      compare("R5 misaligned tail");
      run_req(2, 0, 32'h8000, 4096, 32'h4000, 1'b0);
      model(2, 0, 32'h8000, 4096, 32'h4000);
      compare("R6 unusable large size");
   endtask

   task automatic t_cfg;
      eng_lat = 1; eng_err_at = -1;
      run_req(2, 0, 32'h1000, 32'h3000, 0, 1'b0);
      model(2, 0, 32'h1000, 32'h3000, 0);
      compare("R7 no usable size");
      run_req(2, 0, 32'h8000, 32768, 4096, 1'b0);
      model(2, 0, 32'h8000, 32768, 4096);
      compare("R7 small above large");
   endtask

   task automatic t_zero;
      run_req(1, 32'h100, 0, 4096, 65536, 1'b0);
      chk(got_status == 0 && n_rec == 0, "R10 zero size", n_rec, 0);
      chk(wait_n == 1, "R10 zero size latency", wait_n, 1);
   endtask

   task automatic t_timeout;
      eng_lat = 0; eng_err_at = -1;
      run_req(0, 0, 64, 4096, 65536, 1'b0);
      chk(got_status == 3, "R8 timeout status", got_status, 3);
      chk(n_rec == 1, "R8 timeout chunks", n_rec, 1);
      chk(done_cyc - rec_cyc[0] == IVL * MAXP, "R8 timeout delay",
          done_cyc - rec_cyc[0], IVL * MAXP);
      eng_lat = 1;
   endtask

   task automatic t_engerr;
      eng_lat = 1; eng_err_at = 1;
      run_req(0, 0, 600, 4096, 65536, 1'b0);
      chk(got_status == 4, "R11 engine error status", got_status, 4);
      chk(n_rec == 2, "R11 no chunk after error", n_rec, 2);
      eng_err_at = -1;
   endtask

   task automatic t_busy;
      eng_lat = 1; eng_err_at = -1;
      run_req(1, 32'h80, 300, 4096, 65536, 1'b1);
      model(1, 32'h80, 300, 4096, 65536);
      compare("R13 request while busy");
      n_rec = 0;
      repeat (4) @(negedge clk);
      chk(n_rec == 0 && req_ready == 1'b1, "R13 nothing started after", n_rec, 0);
      chk(dbl == 0, "R12 single-cycle strobe", dbl, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_read;
      t_prog;
      t_erase;
      t_cfg;
      t_zero;
      t_timeout;
      t_engerr;
      t_busy;
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule